// File: doc/BRIEF.md
# Burst SPI Master with Register Interface

This block is an SPI master controlled through eight word-wide registers on a simple memory-mapped bus. Software loads 32-bit words into a transmit FIFO and programs a burst length of 1 to 4096 bits. It picks one of four chip selects and sets the exchange bit. The block then drives a single uninterrupted burst on SCLK/MOSI. It keeps the chosen chip select asserted for the whole burst, and it assembles the bits arriving on MISO into words in a receive FIFO.

When the bit count is not a multiple of 32, the first FIFO word carries only the leftover bits, right-aligned. Every word after it carries 32 bits. Bits go out and come in most significant bit first. Clock phase, clock polarity, chip-select active level and idle SCLK level are set separately for each chip select. A status register reports burst completion and receive overflow, and software clears each flag by writing 1 to it.

Top module: `spi_burst_master`

## Requirements
- R1: The register file sits at word addresses 0 to 7: receive data (0, a read pops the RX FIFO), transmit data (1, a write pushes the TX FIFO, and a write while the FIFO is full is dropped), control (2), per-select configuration (3), interrupt enable (4), DMA control (5), status (6) and period (7). Registers 3, 4, 5 and 7 read back the last value written.
- R2: Control bit 0 enables the block. Writing control with bits 0 and 2 both set starts a burst. Control bit 2 reads 1 while the burst runs and clears itself when the burst ends. Writing bit 2 with bit 0 clear starts nothing.
- R3: Control bits 31:20 hold the burst length minus one, in bits. A burst produces exactly that many plus one SCLK leading edges, up to 4096.
- R4: When the length N is not a multiple of 32, the first TX word supplies its low N mod 32 bits. Every later word supplies all 32 bits. Each word is shifted out MSB first.
- R5: Each received word is pushed to the RX FIFO when its last bit arrives, right-aligned. The first word of a short burst holds N mod 32 bits.
- R6: Status bit 7 is set when a burst ends. Status bit 6 is set when a received word finds the RX FIFO full, and that word is dropped. Writing 1 to either bit clears it.
- R7: Control bits 19:18 pick the chip select used. During the burst, output cs_out[n] sits at configuration bit 12+n. At all other times it sits at the inverse of that bit. It does not change during a burst.
- R8: Configuration bit n is the clock phase for chip select n, and bit 4+n is its polarity. SCLK rests at the polarity level. With phase 0, data is valid on the leading edge. With phase 1, data changes on the leading edge and is valid on the trailing edge.
- R9: Outside a burst, SCLK sits at configuration bit 20+s, where s is the chip select currently named in the control register.
- R10: If the TX FIFO is empty when a word is due, that word is shifted out as zeros.
- R11: After reset, every register reads 0, SCLK is 0 and all four chip selects are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 4 | Chip select outputs, levels set per select |

## Verification
The bench aims at four weak spots:
- A 40-bit burst with a short leading word. A design that packed the short word left-aligned, or that counted every word as 32 bits, would send the wrong bits or the wrong number of edges.
- A phase-1, polarity-1 burst on an active-high select with MOSI looped back to MISO. Sampling on the wrong edge would shift the received words by one bit, and using the wrong select level would flag the chip-select check.
- A 64-bit burst with only one word loaded. It must send 32 zeros rather than repeat stale data.
- A full 4096-bit burst. It must overflow the 64-word RX FIFO, set the overflow flag and keep the oldest words. The bench then tests the write-one-to-clear behaviour of both flags and checks that an exchange request with the block disabled does nothing.

// File: rtl/spi_burst_pkg.sv
// Shared register map and constants for the burst SPI master.
// Assumes a 32-bit register bus with word addressing.
package spi_burst_pkg;
    localparam int REG_W    = 32;
    localparam int NUM_SEL  = 4;
    localparam int LEN_W    = 12;
    localparam int LEN_LSB  = 20;
    localparam int CHAN_LSB = 18;
    localparam int PHA_LSB  = 0;
    localparam int POL_LSB  = 4;
    localparam int ACT_LSB  = 12;
    localparam int IDLE_LSB = 20;
    localparam int BIT_EN   = 0;
    localparam int BIT_XCH  = 2;
    localparam int BIT_TC   = 7;
    localparam int BIT_OVF  = 6;

    typedef enum logic [2:0] {
        REG_RX     = 3'd0,
        REG_TX     = 3'd1,
        REG_CTRL   = 3'd2,
        REG_CFG    = 3'd3,
        REG_INTR   = 3'd4,
        REG_DMA    = 3'd5,
        REG_STAT   = 3'd6,
        REG_PERIOD = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/spi_burst_fifo.sv
// Show-ahead synchronous FIFO. The head word is visible whenever the FIFO is
// not empty. Push when full and pop when empty are ignored.
// Assumes DEPTH is a power of two.
module spi_burst_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    // R6
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (cnt == (AW+1)'(DEPTH)) || $past(do_pop));
endmodule

// File: rtl/spi_burst_engine.sv
// Serial engine: runs one burst of len+1 bits. The first word carries the
// leftover bits right-aligned and every later word carries WORD_W bits.
// Assumes start is only raised while idle, and that mode inputs are
// stable in the start cycle.
module spi_burst_engine #(
    parameter int WORD_W   = 32,
    parameter int LEN_W    = 12,
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              cpha,
    input  logic              cpol,
    input  logic              sclk_idle,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi
);
    localparam int SUB_W = $clog2(WORD_W);
    localparam int CW    = SUB_W + 1;
    localparam int TOT_W = LEN_W + 1;
    localparam int DIV_W = $clog2(HALF_CYC + 1);

    logic              busy_q, h_q, cpha_q, cpol_q, mosi_q;
    logic [DIV_W-1:0]  div_q;
    logic [CW-1:0]     wbits_q, first_k;
    logic [TOT_W-1:0]  left_q;
    logic [WORD_W-1:0] sreg_q, rx_q, rx_next, tx_in;
    logic              half_end, bit_end, samp, word_end, last_bit, go;

    assign go       = start && !busy_q;
    assign half_end = busy_q && (div_q == DIV_W'(HALF_CYC - 1));
    assign bit_end  = half_end && h_q;
    assign samp     = half_end && (h_q == cpha_q);
    assign rx_next  = samp ? {rx_q[WORD_W-2:0], miso} : rx_q;
    assign word_end = bit_end && (wbits_q == CW'(1));
    assign last_bit = bit_end && (left_q == TOT_W'(1));
    assign tx_in    = tx_empty ? '0 : tx_word;
    assign first_k  = CW'(len[SUB_W-1:0]) + CW'(1);

    assign tx_pop  = go || (word_end && !last_bit);
    assign rx_push = word_end;
    assign rx_word = rx_next;
    assign done    = last_bit;
    assign busy    = busy_q;
    assign sclk    = busy_q ? (cpol_q ^ h_q) : sclk_idle;
    assign mosi    = cpha_q ? mosi_q : sreg_q[WORD_W-1];

    // Burst sequencing: clock halves, bit and word counting, shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            h_q     <= 1'b0;
            cpha_q  <= 1'b0;
            cpol_q  <= 1'b0;
            mosi_q  <= 1'b0;
            div_q   <= '0;
            wbits_q <= '0;
            left_q  <= '0;
            sreg_q  <= '0;
            rx_q    <= '0;
        end else if (go) begin
            busy_q  <= 1'b1;
            h_q     <= 1'b0;
            div_q   <= '0;
            cpha_q  <= cpha;
            cpol_q  <= cpol;
            mosi_q  <= 1'b0;
            sreg_q  <= tx_in << (CW'(WORD_W) - first_k);
            wbits_q <= first_k;
            left_q  <= TOT_W'(len) + TOT_W'(1);
            rx_q    <= '0;
        end else if (busy_q) begin
            div_q <= half_end ? '0 : div_q + 1'b1;
            if (samp) rx_q <= rx_next;
            if (half_end) h_q <= ~h_q;
            if (half_end && !h_q && cpha_q) mosi_q <= sreg_q[WORD_W-1];
            if (bit_end) begin
                left_q <= left_q - 1'b1;
                if (last_bit) busy_q <= 1'b0;
                if (word_end) begin
                    rx_q    <= '0;
                    sreg_q  <= tx_in;
                    wbits_q <= CW'(WORD_W);
                end else begin
                    sreg_q  <= sreg_q << 1;
                    wbits_q <= wbits_q - 1'b1;
                end
            end
        end
    end

    // R2
    burst_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R3
    count_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (left_q != '0) && (wbits_q != '0));
endmodule

// File: rtl/spi_burst_master.sv
// Register-programmed burst SPI master: register file, TX and RX FIFOs,
// chip-select decode and the serial engine.
// Assumes one bus access per bus_sel cycle; read data is combinational.
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int HALF_CYC   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  cs_out
);
    localparam int CH_W = $clog2(NUM_SEL);

    logic [REG_W-1:0] ctrl_q, cfg_q, intr_q, dma_q, period_q;
    logic             tc_q, ovf_q, start_q;
    logic [CH_W-1:0]  chan, chan_q;
    logic             wr, rd_rx;
    logic [REG_W-1:0] tx_head, rx_head, rx_word;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic             tx_pop, rx_push, eng_busy, eng_done;

    assign wr    = bus_sel && bus_wr;
    assign rd_rx = bus_sel && !bus_wr && (bus_addr == REG_RX);
    assign chan  = ctrl_q[CHAN_LSB +: CH_W];

    // Register writes and burst start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cfg_q    <= '0;
            intr_q   <= '0;
            dma_q    <= '0;
            period_q <= '0;
            start_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (wr) begin
                unique case (bus_addr)
                    REG_CTRL: begin
                        ctrl_q <= bus_wdata & ~(REG_W'(1) << BIT_XCH);
                        start_q <= bus_wdata[BIT_EN] && bus_wdata[BIT_XCH]
                                   && !eng_busy && !start_q;
                    end
                    REG_CFG:    cfg_q    <= bus_wdata;
                    REG_INTR:   intr_q   <= bus_wdata;
                    REG_DMA:    dma_q    <= bus_wdata;
                    REG_PERIOD: period_q <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Status flags: set by events, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q  <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (eng_done) tc_q <= 1'b1;
            else if (wr && bus_addr == REG_STAT && bus_wdata[BIT_TC]) tc_q <= 1'b0;
            if (rx_push && rx_full) ovf_q <= 1'b1;
            else if (wr && bus_addr == REG_STAT && bus_wdata[BIT_OVF]) ovf_q <= 1'b0;
        end
    end

    // Select captured at burst start, held for the burst.
    always_ff @(posedge clk) begin
        if (!rst_n)       chan_q <= '0;
        else if (start_q) chan_q <= chan;
    end

    // Read data selection.
    always_comb begin
        unique case (bus_addr)
            REG_RX:     bus_rdata = rx_empty ? '0 : rx_head;
            REG_CTRL:   bus_rdata = ctrl_q | (REG_W'(eng_busy | start_q) << BIT_XCH);
            REG_CFG:    bus_rdata = cfg_q;
            REG_INTR:   bus_rdata = intr_q;
            REG_DMA:    bus_rdata = dma_q;
            REG_STAT:   bus_rdata = (REG_W'(tc_q) << BIT_TC) | (REG_W'(ovf_q) << BIT_OVF);
            REG_PERIOD: bus_rdata = period_q;
            default:    bus_rdata = '0;
        endcase
    end

    // Per-select chip-select level decode.
    for (genvar n = 0; n < NUM_SEL; n++) begin : g_cs
        assign cs_out[n] = (eng_busy && chan_q == CH_W'(n)) ? cfg_q[ACT_LSB+n]
                                                            : ~cfg_q[ACT_LSB+n];
    end

    spi_burst_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n),
        .push(wr && bus_addr == REG_TX), .push_data(bus_wdata),
        .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full)
    );

    spi_burst_fifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_word),
        .pop(rd_rx), .head(rx_head), .empty(rx_empty), .full(rx_full)
    );

    spi_burst_engine #(.WORD_W(REG_W), .LEN_W(LEN_W), .HALF_CYC(HALF_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(start_q), .len(ctrl_q[LEN_LSB +: LEN_W]),
        .cpha(cfg_q[PHA_LSB + 32'(chan)]), .cpol(cfg_q[POL_LSB + 32'(chan)]),
        .sclk_idle(cfg_q[IDLE_LSB + 32'(chan)]),
        .tx_word(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word), .miso(miso),
        .busy(eng_busy), .done(eng_done), .sclk(sclk), .mosi(mosi)
    );

    // R6
    tc_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> tc_q);
    // R6
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == REG_STAT && bus_wdata[BIT_OVF] && !(rx_push && rx_full))
        |=> !ovf_q);
    // R7
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && $past(eng_busy) && !$past(wr && bus_addr == REG_CFG))
        |-> $stable(cs_out));
    // R1
    tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == REG_TX && tx_full && !tx_pop) |=> tx_full);
endmodule

// File: tb/spi_burst_master_tb.sv
// Scoreboard bench: the burst task queues expected MOSI bits and RX words.
// The monitor pops bits on each data-valid SCLK edge. MISO is looped to MOSI.
module spi_burst_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_out;

    int n_chk = 0, n_fail = 0;
    bit          exp_q[$];
    logic [31:0] rxexp_q[$];
    bit mon_on = 0, mon_cpol = 0, mon_cpha = 0, mon_act = 0;
    int mon_chan = 0, lead_cnt = 0, bit_err = 0, cs_err = 0;
    logic sclk_prev = 1'b0;

    always #2 clk = ~clk;
    assign miso = mosi;

    spi_burst_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_out(cs_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic take_bit();
        if (exp_q.size() == 0) bit_err++;
        else if (exp_q.pop_front() !== mosi) bit_err++;
    endtask

    // Monitor: pop one expected bit per data-valid edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (sclk_prev == mon_cpol && sclk != mon_cpol) begin
                lead_cnt++;
                if (!mon_cpha) take_bit();
                if (cs_out[mon_chan] !== mon_act) cs_err++;
            end
            if (sclk_prev != mon_cpol && sclk == mon_cpol && mon_cpha) take_bit();
        end
        sclk_prev = sclk;
    end

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 20000 && !s[7]; i++) bus_read(3'd6, s);
    endtask

    task automatic run_burst(input int nbits, input int chan, input bit cpha,
                             input bit cpol, input bit act,
                             input logic [31:0] w [3], input int nw);
        int k, nwords;
        logic [31:0] d;
        k = (nbits % 32 == 0) ? 32 : nbits % 32;
        nwords = 1 + (nbits - k) / 32;
        for (int i = 0; i < nwords; i++) begin
            logic [31:0] word;
            int bits;
            word = (i < nw) ? w[i] : 32'h0;
            bits = (i == 0) ? k : 32;
            for (int b = bits - 1; b >= 0; b--) exp_q.push_back(word[b]);
            rxexp_q.push_back(bits == 32 ? word : (word & ((32'h1 << bits) - 1)));
        end
        for (int i = 0; i < nw; i++) bus_write(3'd1, w[i]);
        mon_cpol = cpol; mon_cpha = cpha; mon_chan = chan; mon_act = act;
        lead_cnt = 0; bit_err = 0; cs_err = 0; mon_on = 1;
        bus_write(3'd2, (32'(nbits - 1) << 20) | (32'(chan) << 18) | 32'hF5);
        wait_done();
        mon_on = 0;
        check(lead_cnt == nbits, "R3", "leading edge count", lead_cnt, nbits);
        check(bit_err == 0 && exp_q.size() == 0, "R4", "mosi bit errors", bit_err, 0);
        check(cs_err == 0, "R7", "cs level during burst", cs_err, 0);
        check(cs_out[chan] === ~act, "R7", "cs after burst", cs_out, ~act);
        bus_read(3'd2, d);
        check(d[2] == 1'b0, "R2", "exchange bit self-clear", d, d & ~32'h4);
        while (rxexp_q.size() > 0) begin
            logic [31:0] e;
            e = rxexp_q.pop_front();
            bus_read(3'd0, d);
            check(d == e, "R5", "rx word", d, e);
        end
        bus_write(3'd6, 32'h80);
        bus_read(3'd6, d);
        check(d[7] == 1'b0, "R6", "tc cleared by write-one", d, 32'h0);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int zeros;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R11 reset state
        #1;
        check(cs_out === 4'hF, "R11", "cs after reset", cs_out, 4'hF);
        check(sclk === 1'b0, "R11", "sclk after reset", sclk, 0);
        bus_read(3'd2, d); check(d == 0, "R11", "ctrl after reset", d, 0);
        bus_read(3'd6, d); check(d == 0, "R11", "stat after reset", d, 0);
        // R1 plain registers read back
        bus_write(3'd4, 32'h0000_1234); bus_read(3'd4, d);
        check(d == 32'h1234, "R1", "intr readback", d, 32'h1234);
        bus_write(3'd5, 32'h0000_00A5); bus_read(3'd5, d);
        check(d == 32'hA5, "R1", "dma readback", d, 32'hA5);
        bus_write(3'd7, 32'h0000_8000); bus_read(3'd7, d);
        check(d == 32'h8000, "R1", "period readback", d, 32'h8000);
        // R4 R5 full word, phase 0, select 0 active low
        run_burst(32, 0, 0, 0, 0, '{32'hA5C3_0F1E, 32'h0, 32'h0}, 1);
        // R8 R9 phase 1 polarity 1, select 2 active high, idle high
        bus_write(3'd3, 32'h0040_4044);
        bus_read(3'd3, d); check(d == 32'h0040_4044, "R1", "config readback", d, 32'h0040_4044);
        bus_write(3'd2, 32'h0008_0000);
        #1;
        check(sclk === 1'b1, "R9", "idle sclk for select 2", sclk, 1);
        check(cs_out[2] === 1'b0, "R7", "inactive active-high select", cs_out, 4'hB);
        run_burst(40, 2, 1, 1, 1, '{32'h0000_005A, 32'h1234_5678, 32'h0}, 2);
        check(sclk === 1'b1, "R9", "sclk back to idle", sclk, 1);
        // R2 exchange without enable does nothing
        bus_write(3'd2, 32'h0000_0004);
        repeat (20) @(negedge clk);
        bus_read(3'd6, d); check(d[7] == 1'b0, "R2", "no burst when disabled", d, 0);
        bus_read(3'd2, d); check(d[2] == 1'b0, "R2", "no exchange when disabled", d, 0);
        // R10 underflow shifts zeros
        run_burst(64, 1, 0, 0, 0, '{32'hDEAD_BEEF, 32'h0, 32'h0}, 1);
        // R3 R6 maximum burst overflows the RX FIFO
        for (int i = 0; i < 4096; i++) exp_q.push_back(1'b0);
        mon_cpol = 0; mon_cpha = 0; mon_chan = 0; mon_act = 0;
        lead_cnt = 0; bit_err = 0; cs_err = 0; mon_on = 1;
        bus_write(3'd2, 32'hFFF0_00F5);
        wait_done();
        mon_on = 0;
        check(lead_cnt == 4096, "R3", "max length edges", lead_cnt, 4096);
        check(bit_err == 0 && exp_q.size() == 0, "R10", "zeros on empty tx", bit_err, 0);
        bus_read(3'd6, d); check(d[6] == 1'b1, "R6", "overflow flag", d, 32'hC0);
        bus_write(3'd6, 32'h40);
        bus_read(3'd6, d); check(d[6] == 1'b0, "R6", "overflow cleared", d, 32'h80);
        zeros = 0;
        for (int i = 0; i < 64; i++) begin
            bus_read(3'd0, d);
            if (d == 0) zeros++;
        end
        check(zeros == 64, "R5", "rx words kept in overflow", zeros, 64);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule